// File: doc/BRIEF.md
# Memory Clock Glitch-Free Switch Sequencer

This block retunes the memory clock PLL of a clock generator without ever letting a runt pulse reach the memory clock pin. One start pulse runs a fixed list of register accesses on an indexed register bus. First it reads and keeps the three pixel PLL parameter bytes. It then tunes the pixel PLL to the new frequency and lets it settle. Next it steers the dot clock onto the memory clock output, using a two-write strobe in which a 0-to-1 edge on one control bit latches the select bit. With the output covered, it disables and reloads the memory PLL, waits for lock and steers the memory PLL back onto the pin. Last, it reloads the pixel PLL with the saved bytes.

The new N, M and P bytes and a VGA-enabled flag are captured when the start pulse is accepted. Every access waits for a bus acknowledge. Between phases the block raises a lock-wait request towards an external lock poller, which answers with a completion and an error flag. A lock error does not cut the run short, because the clock selects must still be put back. The block records the error and still finishes the whole list. A one-cycle done pulse closes every run.

Top module: `mclk_switch_seq`

## Requirements
- R1: While reset is asserted and after it is released, bus_req, lock_req, done and err are all 0 until a start is accepted.
- R2: Register indices are 0 = PLL address, 1 = pixel PLL data, 2 = memory PLL data, 3 = clock select, 4 = memory clock control. lock_sel is 0 for the pixel PLL and 1 for the memory PLL.
- R3: Before any write to PLL data, the block reads pixel PLL data three times, after writing addresses 0xFC, 0xFD and 0xFE in turn, and keeps the three bytes.
- R4: The pixel PLL is disabled (address 0xFE, data 0x00), then loaded at address 0xFC with N&0x3F|0xC0, M&0x3F and P&0x03|0xB0 in that order, then one pixel lock wait follows.
- R5: With vga_en captured high, clock select is written 0x75 after the first pixel lock and 0x77 after the memory clock switches back. With vga_en low, neither write occurs.
- R6: The pixel PLL is restarted by writing address 0xFE then P&0x03|0x30, and address 0xFE then P&0x03|0xB0, followed by a pixel lock wait.
- R7: The control byte is read exactly once, then written as val&0xE7 and then as val&0xE7|0x08.
- R8: The memory PLL is disabled (address 0xFB, memory data 0x00), loaded at address 0xF3 with the same three-byte pattern as R4, and followed by a memory lock wait.
- R9: The control byte is then written as val&0xE7|0x10 and then as val&0xE7|0x18.
- R10: The pixel PLL is disabled again (0xFE, 0x00), reloaded at 0xFC with the three bytes saved under R3 unchanged, and followed by a final pixel lock wait.
- R11: Any lock completion with lock_err high sets err. The run still performs every remaining access. err stays set through done and clears when the next start is accepted.
- R12: While a request is not yet acknowledged, it stays asserted with unchanged index, direction, data and lock_sel. A start pulse while a run is in progress is ignored.
- R13: done is a single-cycle pulse after the last lock wait completes, with no bus or lock request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| vga_en | input | 1 | Clock select must be switched around the handover |
| n_val | input | 8 | New N parameter |
| m_val | input | 8 | New M parameter |
| p_val | input | 8 | New P parameter |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_idx | output | 3 | Register index |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes at this clock edge |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| lock_req | output | 1 | Lock wait request |
| lock_sel | output | 1 | PLL to wait on |
| lock_done | input | 1 | Lock wait finished |
| lock_err | input | 1 | Lock wait timed out (with lock_done) |
| done | output | 1 | Run finished (one cycle) |
| err | output | 1 | A lock wait failed during the run |

## Verification
The hardest case to reach is a lock failure in the middle of the handover, while the memory PLL is being reloaded and the dot clock is covering the pin. Only then does the rule that the run goes on to completion decide whether the control byte and clock select are put back. The stimulus table gives each run a mask that makes chosen lock waits fail. The bus responder stalls every other acknowledge, so each request is held across a wait. One run receives a second start pulse halfway through, and another is cut by reset mid-sequence before a clean rerun.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 8;
  localparam int NSTEP  = 39;
  localparam int STEP_W = $clog2(NSTEP);

  localparam logic [IDX_W-1:0] IX_ADDR = 3'd0;
  localparam logic [IDX_W-1:0] IX_PIX  = 3'd1;
  localparam logic [IDX_W-1:0] IX_MEM  = 3'd2;
  localparam logic [IDX_W-1:0] IX_CSEL = 3'd3;
  localparam logic [IDX_W-1:0] IX_MCTL = 3'd4;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_LOCK} op_e;
  typedef enum logic [3:0] {S_K, S_N, S_M, S_PB0, S_P30, S_V, S_V08, S_V10, S_V18,
                            S_SN, S_SM, S_SP} src_e;
  typedef enum logic [2:0] {D_NONE, D_SN, D_SM, D_SP, D_V} dst_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
    src_e             src;
    logic [DATA_W-1:0] k;
    dst_e             dst;
    logic             vga_only;
    logic             lk_mem;
    logic             last;
  } step_t;

  function automatic step_t mk_wr(logic [IDX_W-1:0] idx, src_e src,
                                  logic [DATA_W-1:0] k, logic vga_only);
    step_t s;
    s = '0;
    s.op = OP_WR; s.idx = idx; s.src = src; s.k = k; s.vga_only = vga_only;
    return s;
  endfunction

  function automatic step_t mk_rd(logic [IDX_W-1:0] idx, dst_e dst);
    step_t s;
    s = '0;
    s.op = OP_RD; s.idx = idx; s.dst = dst;
    return s;
  endfunction

  function automatic step_t mk_lk(logic mem);
    step_t s;
    s = '0;
    s.op = OP_LOCK; s.lk_mem = mem;
    return s;
  endfunction
endpackage

// File: rtl/mcs_step_rom.sv
module mcs_step_rom
  import mcs_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output step_t             op_o
);
  always_comb begin
    case (step)
      // R3 save pixel bytes
      6'd0:  op_o = mk_wr(IX_ADDR, S_K, 8'hFC, 1'b0);
      6'd1:  op_o = mk_rd(IX_PIX, D_SN);
      6'd2:  op_o = mk_wr(IX_ADDR, S_K, 8'hFD, 1'b0);
      6'd3:  op_o = mk_rd(IX_PIX, D_SM);
      6'd4:  op_o = mk_wr(IX_ADDR, S_K, 8'hFE, 1'b0);
      6'd5:  op_o = mk_rd(IX_PIX, D_SP);
      // R4 tune pixel PLL
      6'd6:  op_o = mk_wr(IX_ADDR, S_K, 8'hFE, 1'b0);
      6'd7:  op_o = mk_wr(IX_PIX, S_K, 8'h00, 1'b0);
      6'd8:  op_o = mk_wr(IX_ADDR, S_K, 8'hFC, 1'b0);
      6'd9:  op_o = mk_wr(IX_PIX, S_N, 8'h00, 1'b0);
      6'd10: op_o = mk_wr(IX_PIX, S_M, 8'h00, 1'b0);
      6'd11: op_o = mk_wr(IX_PIX, S_PB0, 8'h00, 1'b0);
      6'd12: op_o = mk_lk(1'b0);
      // R5 internal clock, R6 restart pixel PLL
      6'd13: op_o = mk_wr(IX_CSEL, S_K, 8'h75, 1'b1);
      6'd14: op_o = mk_wr(IX_ADDR, S_K, 8'hFE, 1'b0);
      6'd15: op_o = mk_wr(IX_PIX, S_P30, 8'h00, 1'b0);
      6'd16: op_o = mk_wr(IX_ADDR, S_K, 8'hFE, 1'b0);
      6'd17: op_o = mk_wr(IX_PIX, S_PB0, 8'h00, 1'b0);
      6'd18: op_o = mk_lk(1'b0);
      // R7 dot clock onto memory clock pin
      6'd19: op_o = mk_rd(IX_MCTL, D_V);
      6'd20: op_o = mk_wr(IX_MCTL, S_V, 8'h00, 1'b0);
      6'd21: op_o = mk_wr(IX_MCTL, S_V08, 8'h00, 1'b0);
      // R8 memory PLL
      6'd22: op_o = mk_wr(IX_ADDR, S_K, 8'hFB, 1'b0);
      6'd23: op_o = mk_wr(IX_MEM, S_K, 8'h00, 1'b0);
      6'd24: op_o = mk_wr(IX_ADDR, S_K, 8'hF3, 1'b0);
      6'd25: op_o = mk_wr(IX_MEM, S_N, 8'h00, 1'b0);
      6'd26: op_o = mk_wr(IX_MEM, S_M, 8'h00, 1'b0);
      6'd27: op_o = mk_wr(IX_MEM, S_PB0, 8'h00, 1'b0);
      6'd28: op_o = mk_lk(1'b1);
      // R9 memory PLL back on pin, R5 external clock
      6'd29: op_o = mk_wr(IX_MCTL, S_V10, 8'h00, 1'b0);
      6'd30: op_o = mk_wr(IX_MCTL, S_V18, 8'h00, 1'b0);
      6'd31: op_o = mk_wr(IX_CSEL, S_K, 8'h77, 1'b1);
      // R10 restore pixel PLL
      6'd32: op_o = mk_wr(IX_ADDR, S_K, 8'hFE, 1'b0);
      6'd33: op_o = mk_wr(IX_PIX, S_K, 8'h00, 1'b0);
      6'd34: op_o = mk_wr(IX_ADDR, S_K, 8'hFC, 1'b0);
      6'd35: op_o = mk_wr(IX_PIX, S_SN, 8'h00, 1'b0);
      6'd36: op_o = mk_wr(IX_PIX, S_SM, 8'h00, 1'b0);
      6'd37: op_o = mk_wr(IX_PIX, S_SP, 8'h00, 1'b0);
      default: op_o = mk_lk(1'b0);
    endcase
    op_o.last = (step == STEP_W'(NSTEP - 1));
  end
endmodule

// File: rtl/mcs_operand_bank.sv
module mcs_operand_bank
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] n_in,
  input  logic [DATA_W-1:0] m_in,
  input  logic [DATA_W-1:0] p_in,
  input  logic              vga_in,
  input  logic              cap_en,
  input  dst_e              cap_dst,
  input  logic [DATA_W-1:0] cap_data,
  input  src_e              src,
  input  logic [DATA_W-1:0] k,
  output logic [DATA_W-1:0] wdata,
  output logic              vga_q
);
  logic [DATA_W-1:0] n_q, m_q, p_q, sn_q, sm_q, sp_q, cv_q;
  logic [DATA_W-1:0] cv_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0; m_q <= '0; p_q <= '0; vga_q <= 1'b0;
    end else if (load_en) begin
      n_q <= n_in; m_q <= m_in; p_q <= p_in; vga_q <= vga_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sn_q <= '0; sm_q <= '0; sp_q <= '0; cv_q <= '0;
    end else if (cap_en) begin
      case (cap_dst)
        D_SN:    sn_q <= cap_data;
        D_SM:    sm_q <= cap_data;
        D_SP:    sp_q <= cap_data;
        D_V:     cv_q <= cap_data;
        default: ;
      endcase
    end
  end

  assign cv_base = cv_q & 8'hE7;

  always_comb begin
    case (src)
      S_N:     wdata = {2'b11, n_q[5:0]};
      S_M:     wdata = {2'b00, m_q[5:0]};
      S_PB0:   wdata = {6'b101100, p_q[1:0]};
      S_P30:   wdata = {6'b001100, p_q[1:0]};
      S_V:     wdata = cv_base;
      S_V08:   wdata = cv_base | 8'h08;
      S_V10:   wdata = cv_base | 8'h10;
      S_V18:   wdata = cv_base | 8'h18;
      S_SN:    wdata = sn_q;
      S_SM:    wdata = sm_q;
      S_SP:    wdata = sp_q;
      default: wdata = k;
    endcase
  end
endmodule

// File: rtl/mclk_switch_seq.sv
module mclk_switch_seq
  import mcs_pkg::*;
#(
  parameter int RST_SYNC = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       vga_en,
  input  logic [7:0] n_val,
  input  logic [7:0] m_val,
  input  logic [7:0] p_val,
  output logic       bus_req,
  output logic       bus_we,
  output logic [2:0] bus_idx,
  output logic [7:0] bus_wdata,
  input  logic       bus_ack,
  input  logic [7:0] bus_rdata,
  output logic       lock_req,
  output logic       lock_sel,
  input  logic       lock_done,
  input  logic       lock_err,
  output logic       done,
  output logic       err
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  logic [RST_SYNC-1:0] rs_q;
  logic                rst_s;
  st_e                 st_q, st_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                err_q, err_d;
  step_t               cur;
  logic                vga_q, skip, step_fin, accept;
  logic [DATA_W-1:0]   wdata;

  // reset asserts at once, releases after RST_SYNC edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_s = rs_q[RST_SYNC-1];

  mcs_step_rom u_rom (.step(step_q), .op_o(cur));

  mcs_operand_bank u_bank (
    .clk(clk), .rst_n(rst_s), .load_en(accept),
    .n_in(n_val), .m_in(m_val), .p_in(p_val), .vga_in(vga_en),
    .cap_en(bus_req && bus_ack && (cur.op == OP_RD)), .cap_dst(cur.dst),
    .cap_data(bus_rdata), .src(cur.src), .k(cur.k),
    .wdata(wdata), .vga_q(vga_q)
  );

  assign accept    = (st_q == ST_IDLE) && start;
  assign skip      = cur.vga_only && !vga_q;
  assign bus_req   = (st_q == ST_RUN) && (cur.op != OP_LOCK) && !skip;
  assign lock_req  = (st_q == ST_RUN) && (cur.op == OP_LOCK);
  assign bus_we    = (cur.op == OP_WR);
  assign bus_idx   = cur.idx;
  assign bus_wdata = wdata;
  assign lock_sel  = cur.lk_mem;
  assign done      = (st_q == ST_DONE);
  assign err       = err_q;
  assign step_fin  = (st_q == ST_RUN) &&
                     (skip || (bus_req && bus_ack) || (lock_req && lock_done));

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    err_d  = err_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_RUN;
        step_d = '0;
        err_d  = 1'b0;
      end
      ST_RUN: begin
        if (lock_req && lock_done && lock_err) err_d = 1'b1;
        if (step_fin) begin
          if (cur.last) st_d = ST_DONE;
          else          step_d = step_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      err_q  <= err_d;
    end
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    bus_req && !bus_ack |=> bus_req && $stable(bus_idx) && $stable(bus_we) && $stable(bus_wdata));
  // R12
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    lock_req && !lock_done |=> lock_req && $stable(lock_sel));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R13
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !bus_req && !lock_req);
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err && !start |=> err);
endmodule

// File: tb/mclk_switch_seq_tb.sv
module mclk_switch_seq_tb;
  typedef struct packed {
    logic [7:0] n, m, p;
    logic       vga;
    logic [3:0] emask;
    logic [7:0] pn, pm, pp, ctl;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h3A, 8'h21, 8'h02, 1'b1, 4'b0000, 8'hC5, 8'h12, 8'hB1, 8'hFF},
    '{8'hFF, 8'hFF, 8'hFF, 1'b0, 4'b0000, 8'h00, 8'h3F, 8'hF3, 8'h00},
    '{8'h00, 8'h00, 8'h00, 1'b1, 4'b0100, 8'h9E, 8'h44, 8'h01, 8'hA5},
    '{8'h15, 8'h2E, 8'h01, 1'b0, 4'b1001, 8'h7C, 8'h0D, 8'hB2, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n, start, vga_en;
  logic [7:0] n_val, m_val, p_val;
  logic bus_req, bus_we, bus_ack, lock_req, lock_sel, lock_done, lock_err, done, err;
  logic [2:0] bus_idx;
  logic [7:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  mclk_switch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vga_en(vga_en),
    .n_val(n_val), .m_val(m_val), .p_val(p_val),
    .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .lock_req(lock_req), .lock_sel(lock_sel), .lock_done(lock_done), .lock_err(lock_err),
    .done(done), .err(err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [12:0] exp_e [64];
  string       exp_t [64];
  logic [12:0] got_e [64];
  int exp_n, got_n, lock_no, lk_cnt, done_cnt;
  logic err_at_done, tog;
  logic [7:0] pll_addr;
  vec_t cv;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // entry = {kind, idx, data}; kind 1 write, 2 read, 3 lock (idx = lock_sel)
  task automatic add(input logic [1:0] kd, input logic [2:0] ix, input logic [7:0] d,
                     input string tag);
    exp_e[exp_n] = {kd, ix, d};
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build(input vec_t v);
    logic [7:0] nb, mb, pb, cb;
    nb = {2'b11, v.n[5:0]}; mb = {2'b00, v.m[5:0]}; pb = {6'b101100, v.p[1:0]};
    cb = v.ctl & 8'hE7;
    exp_n = 0;
    add(1, 0, 8'hFC, "R2"); add(2, 1, 0, "R3"); add(1, 0, 8'hFD, "R3"); add(2, 1, 0, "R3");
    add(1, 0, 8'hFE, "R3"); add(2, 1, 0, "R3");
    add(1, 0, 8'hFE, "R4"); add(1, 1, 8'h00, "R4"); add(1, 0, 8'hFC, "R4");
    add(1, 1, nb, "R4"); add(1, 1, mb, "R4"); add(1, 1, pb, "R4"); add(3, 0, 0, "R4");
    if (v.vga) add(1, 3, 8'h75, "R5");
    add(1, 0, 8'hFE, "R6"); add(1, 1, {6'b001100, v.p[1:0]}, "R6");
    add(1, 0, 8'hFE, "R6"); add(1, 1, pb, "R6"); add(3, 0, 0, "R6");
    add(2, 4, 0, "R7"); add(1, 4, cb, "R7"); add(1, 4, cb | 8'h08, "R7");
    add(1, 0, 8'hFB, "R8"); add(1, 2, 8'h00, "R8"); add(1, 0, 8'hF3, "R8");
    add(1, 2, nb, "R8"); add(1, 2, mb, "R8"); add(1, 2, pb, "R8"); add(3, 1, 0, "R8");
    add(1, 4, cb | 8'h10, "R9"); add(1, 4, cb | 8'h18, "R9");
    if (v.vga) add(1, 3, 8'h77, "R5");
    add(1, 0, 8'hFE, "R10"); add(1, 1, 8'h00, "R10"); add(1, 0, 8'hFC, "R10");
    add(1, 1, v.pn, "R10"); add(1, 1, v.pm, "R10"); add(1, 1, v.pp, "R10");
    add(3, 0, 0, "R10");
  endtask

  // bus and lock responders, acting at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; lock_done = 1'b0; lock_err = 1'b0; tog = 1'b0; lk_cnt = 0;
    end else begin
      tog = ~tog;
      bus_ack = bus_req && tog;
      if (bus_ack) begin
        if (bus_we) begin
          if (got_n < 64) got_e[got_n] = {2'd1, bus_idx, bus_wdata};
          if (bus_idx == 3'd0) pll_addr = bus_wdata;
        end else begin
          if (got_n < 64) got_e[got_n] = {2'd2, bus_idx, 8'h00};
          if (bus_idx == 3'd4) bus_rdata = cv.ctl;
          else if (pll_addr == 8'hFC) bus_rdata = cv.pn;
          else if (pll_addr == 8'hFD) bus_rdata = cv.pm;
          else if (pll_addr == 8'hFE) bus_rdata = cv.pp;
          else bus_rdata = 8'h00;
        end
        got_n++;
      end
      if (lock_done) begin
        lock_done = 1'b0; lock_err = 1'b0; lk_cnt = 0;
      end else if (lock_req) begin
        lk_cnt++;
        if (lk_cnt == 3) begin
          lock_done = 1'b1;
          lock_err = cv.emask[lock_no[1:0]];
          if (got_n < 64) got_e[got_n] = {2'd3, 2'b00, lock_sel, 8'h00};
          got_n++;
          lock_no++;
        end
      end
      if (done) begin
        done_cnt++;
        err_at_done = err;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R13: actual hung expected done");
      summary();
      $finish;
    end
  end

  task automatic arm(input vec_t v);
    cv = v; n_val = v.n; m_val = v.m; p_val = v.p; vga_en = v.vga;
    build(v);
    got_n = 0; lock_no = 0; done_cnt = 0; err_at_done = 1'b0;
  endtask

  task automatic run(input vec_t v, input bit poke);
    arm(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b0, "R11", "err cleared on start", err, 0);
    for (int t = 0; t < 3000 && done_cnt == 0; t++) begin
      @(negedge clk);
      if (poke && t == 20) start = 1'b1;      // R12 start while busy
      if (poke && t == 21) start = 1'b0;
      vga_en = ~v.vga;                        // R5 flag only sampled at start
    end
    repeat (30) @(negedge clk);
    chk(got_n == exp_n, "R12", "access count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < 64; i++)
      chk(got_e[i] == exp_e[i], exp_t[i], $sformatf("entry %0d", i), got_e[i], exp_e[i]);
    chk(done_cnt == 1, "R13", "done pulses", done_cnt, 1);
    chk(err_at_done == |v.emask, "R11", "err at done", err_at_done, |v.emask);
    chk(!bus_req && !lock_req, "R12", "quiet after done", {bus_req, lock_req}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vga_en = 1'b0; n_val = '0; m_val = '0; p_val = '0;
    bus_rdata = '0; pll_addr = '0; cv = VECS[0];
    got_n = 0; lock_no = 0; done_cnt = 0; err_at_done = 1'b0;
    repeat (3) @(negedge clk);
    chk({bus_req, lock_req, done, err} == 4'b0, "R1", "outputs in reset",
        {bus_req, lock_req, done, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({bus_req, lock_req, done, err} == 4'b0, "R1", "idle after reset",
        {bus_req, lock_req, done, err}, 0);

    for (int i = 0; i < 4; i++) run(VECS[i], i == 1);

    // reset in mid-sequence, then a clean rerun
    arm(VECS[2]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({bus_req, lock_req, done, err} == 4'b0, "R1", "outputs after mid-run reset",
        {bus_req, lock_req, done, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(VECS[0], 1'b0);

    summary();
    $finish;
  end
endmodule